// File: doc/BRIEF.md
# Vector Scatter-Accumulate Byte Log

This block gathers the element requests of one vector scatter-accumulate operation into a log with one slot per byte. It then applies them to an external byte-wide memory as read-modify-write updates. Each slot holds a data byte, the byte address it targets, and a valid bit. While idle, the block takes one halfword or word element per cycle. Each element carries an element index, a base address, a region length and a predicate. The block writes the element's bytes into their slots, and works out each byte's valid bit from the region bound and the predicate.

A start pulse begins the commit pass. The block walks the log one element at a time, from the lowest slot upward, using the element size of the most recent capture. It skips an element when the valid bit of its first byte is clear. For any other element it reads the destination bytes from memory, adds the logged increment at the element width, and writes the sum back byte by byte. It then clears the slots it has consumed. `busy` covers the whole pass, and `done` pulses once at the end.

Top module: `scatter_acc_log`

## Requirements
- R1: An accepted capture with element index `i` and size S (2 when `cap_word`=0, 4 when `cap_word`=1) writes slot S*i+k for k in 0..S-1. Slot S*i+k gets data byte `cap_data[8k+7:8k]` and address (`cap_base`+k) mod 2^ADDR_W. For words only the low IDX_W-1 bits of the index are used. A later capture to the same slot overwrites it.
- R2: The valid bit of byte k is set only when (`cap_base`+k) mod 2^ADDR_W <= (`cap_base`+`cap_len`) mod 2^ADDR_W and `cap_pred`=1. Otherwise the bit is cleared, while the data and address are still stored.
- R3: The element size used by a commit is the size of the most recent accepted capture. After reset it is the halfword size.
- R4: A commit visits elements in ascending slot order with a stride of S. An element is processed exactly when the valid bit of its first slot is set. A processed element then uses all S of its slots, whatever their own valid bits.
- R5: For a processed element, the destination value and the increment are both assembled little-endian (the lower slot is the less significant byte). Their sum, truncated to 8*S bits, is written back little-endian to the logged addresses. A later element that targets the same bytes sees the earlier result.
- R6: Each consumed slot has its valid bit and data cleared. A second commit with no new capture in between leaves memory unchanged.
- R7: A `start` pulse while idle makes `busy` high from the next cycle. `busy` stays high through the cycle in which `done` is high. `done` is a single-cycle pulse, and `busy` is low in the cycle after it.
- R8: While `busy` is high, `cap_valid` and `start` are ignored.
- R9: The memory port makes at most one byte access per cycle. Read data is taken one cycle after a read. `mem_en` is high only while busy, and `mem_we` only together with `mem_en`.
- R10: After reset, `busy`, `done` and `mem_en` are low and every valid bit is clear, so a commit changes no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_valid | input | 1 | Capture one element this cycle |
| cap_word | input | 1 | Element size: 1 = 4 bytes, 0 = 2 bytes |
| cap_idx | input | IDX_W | Element index within the vector |
| cap_base | input | ADDR_W | Byte address of the element's first byte |
| cap_len | input | ADDR_W | Region length that sets the upper byte bound |
| cap_pred | input | 1 | Predicate qualifier for the element |
| cap_data | input | 32 | Increment bytes, little-endian (low half used for 2 bytes) |
| start | input | 1 | Begin the commit pass |
| busy | output | 1 | Commit pass in progress |
| done | output | 1 | One-cycle pulse at the end of the pass |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Write data byte |
| mem_rdata | input | 8 | Read data, valid one cycle after a read |

## Verification
The bench targets a halfword sum of 0xFFFF+1. A design that carried out of the element would corrupt the next byte in memory. A zero region length marks only the first byte. A design that tested every byte's valid bit would then drop the rest of that element, and the bench checks that the whole element is still applied. A region bound that wraps past the top of the address space must leave its element unapplied. Two elements aimed at the same bytes must both land; a design that read before the earlier write completed would lose one. The bench also injects a capture and a second start during a commit, then runs a second commit that must change nothing. A design that accepted either of them, or that failed to clear consumed slots, would modify memory again.

// File: rtl/sal_pkg.sv
package sal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_RD,
        ST_CAP,
        ST_ADD,
        ST_WR,
        ST_FIN
    } sal_state_e;

    localparam int unsigned ELEM_MAX_BYTES = 4;
    localparam int unsigned ELEM_MAX_BITS  = 8 * ELEM_MAX_BYTES;

endpackage

// File: rtl/sal_byte_qual.sv
module sal_byte_qual
    import sal_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]         base,
    input  logic [ADDR_W-1:0]         len,
    input  logic                      pred,
    output logic [ELEM_MAX_BYTES-1:0] byte_ok
);

    logic [ADDR_W-1:0] upper;

    assign upper = base + len;

    for (genvar k = 0; k < ELEM_MAX_BYTES; k++) begin : g_byte
        logic [ADDR_W-1:0] this_addr;
        assign this_addr  = base + ADDR_W'(k);
        assign byte_ok[k] = pred && (this_addr <= upper);
    end

endmodule

// File: rtl/sal_log_store.sv
module sal_log_store
    import sal_pkg::*;
#(
    parameter  int unsigned LOG_BYTES = 128,
    parameter  int unsigned ADDR_W    = 12,
    localparam int unsigned SLOT_W    = $clog2(LOG_BYTES),
    localparam int unsigned IDX_W     = SLOT_W - 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      wr_word,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [ADDR_W-1:0]         wr_base,
    input  logic [ELEM_MAX_BITS-1:0]  wr_data,
    input  logic [ELEM_MAX_BYTES-1:0] wr_ok,
    input  logic [SLOT_W-1:0]         rd_slot,
    output logic                      rd_mask,
    output logic [ADDR_W-1:0]         rd_addr,
    output logic [7:0]                rd_data,
    input  logic                      clr_en,
    output logic                      op_word
);

    logic [7:0]          data_q [LOG_BYTES];
    logic [7:0]          data_d [LOG_BYTES];
    logic [ADDR_W-1:0]   addr_q [LOG_BYTES];
    logic [ADDR_W-1:0]   addr_d [LOG_BYTES];
    logic [LOG_BYTES-1:0] mask_q, mask_d;
    logic                word_q, word_d;
    logic [SLOT_W-1:0]   slot_base;

    // Word elements occupy four slots, halfwords two.
    assign slot_base = wr_word ? {wr_idx[IDX_W-2:0], 2'b00} : {wr_idx, 1'b0};

    always_comb begin
        data_d = data_q;
        addr_d = addr_q;
        mask_d = mask_q;
        word_d = word_q;
        if (wr_en) begin
            word_d = wr_word;
            for (int k = 0; k < int'(ELEM_MAX_BYTES); k++) begin
                if (k < 2 || wr_word) begin
                    data_d[slot_base + SLOT_W'(k)] = wr_data[8*k +: 8];
                    addr_d[slot_base + SLOT_W'(k)] = wr_base + ADDR_W'(k);
                    mask_d[slot_base + SLOT_W'(k)] = wr_ok[k];
                end
            end
        end
        if (clr_en) begin
            mask_d[rd_slot] = 1'b0;
            data_d[rd_slot] = 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < int'(LOG_BYTES); s++) begin
                data_q[s] <= '0;
                addr_q[s] <= '0;
            end
            mask_q <= '0;
            word_q <= 1'b0;
        end else begin
            data_q <= data_d;
            addr_q <= addr_d;
            mask_q <= mask_d;
            word_q <= word_d;
        end
    end

    assign rd_mask = mask_q[rd_slot];
    assign rd_addr = addr_q[rd_slot];
    assign rd_data = data_q[rd_slot];
    assign op_word = word_q;

endmodule

// File: rtl/sal_commit_fsm.sv
module sal_commit_fsm
    import sal_pkg::*;
#(
    parameter  int unsigned LOG_BYTES = 128,
    parameter  int unsigned ADDR_W    = 12,
    localparam int unsigned SLOT_W    = $clog2(LOG_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_word,
    output logic [SLOT_W-1:0] rd_slot,
    input  logic              log_mask,
    input  logic [ADDR_W-1:0] log_addr,
    input  logic [7:0]        log_data,
    output logic              clr_en,
    output logic              busy,
    output logic              done,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);

    typedef struct packed {
        sal_state_e               st;
        logic [SLOT_W-1:0]        slot;
        logic [1:0]               bidx;
        logic [ELEM_MAX_BITS-1:0] dst;
        logic [ELEM_MAX_BITS-1:0] inc;
        logic [ELEM_MAX_BITS-1:0] sum;
    } fsm_t;

    fsm_t r_q, r_d;

    logic [SLOT_W:0]   next_slot;
    logic              at_end;
    logic [1:0]        last_b;
    logic [4:0]        bsh;

    assign last_b    = op_word ? 2'd3 : 2'd1;
    assign next_slot = {1'b0, r_q.slot} + (op_word ? (SLOT_W+1)'(4) : (SLOT_W+1)'(2));
    assign at_end    = next_slot >= (SLOT_W+1)'(LOG_BYTES);
    assign bsh       = {r_q.bidx, 3'b000};
    assign rd_slot   = r_q.slot + SLOT_W'(r_q.bidx);

    always_comb begin
        r_d       = r_q;
        clr_en    = 1'b0;
        done      = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st   = ST_SCAN;
                    r_d.slot = '0;
                    r_d.bidx = '0;
                end
            end
            ST_SCAN: begin
                if (log_mask) begin
                    r_d.st   = ST_RD;
                    r_d.bidx = '0;
                    r_d.dst  = '0;
                    r_d.inc  = '0;
                end else if (at_end) begin
                    r_d.st = ST_FIN;
                end else begin
                    r_d.slot = next_slot[SLOT_W-1:0];
                end
            end
            ST_RD: begin
                mem_en   = 1'b1;
                mem_addr = log_addr;
                r_d.inc[bsh +: 8] = log_data;
                r_d.st   = ST_CAP;
            end
            ST_CAP: begin
                r_d.dst[bsh +: 8] = mem_rdata;
                if (r_q.bidx == last_b) begin
                    r_d.bidx = '0;
                    r_d.st   = ST_ADD;
                end else begin
                    r_d.bidx = r_q.bidx + 2'd1;
                    r_d.st   = ST_RD;
                end
            end
            ST_ADD: begin
                r_d.sum = r_q.dst + r_q.inc;
                if (!op_word) begin
                    r_d.sum[31:16] = '0;
                end
                r_d.st = ST_WR;
            end
            ST_WR: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = log_addr;
                mem_wdata = r_q.sum[bsh +: 8];
                clr_en    = 1'b1;
                if (r_q.bidx == last_b) begin
                    r_d.bidx = '0;
                    if (at_end) begin
                        r_d.st = ST_FIN;
                    end else begin
                        r_d.slot = next_slot[SLOT_W-1:0];
                        r_d.st   = ST_SCAN;
                    end
                end else begin
                    r_d.bidx = r_q.bidx + 2'd1;
                end
            end
            ST_FIN: begin
                done   = 1'b1;
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy = (r_q.st != ST_IDLE);

endmodule

// File: rtl/scatter_acc_log.sv
module scatter_acc_log
    import sal_pkg::*;
#(
    parameter  int unsigned LOG_BYTES = 128,
    parameter  int unsigned ADDR_W    = 12,
    localparam int unsigned SLOT_W    = $clog2(LOG_BYTES),
    localparam int unsigned IDX_W     = SLOT_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_valid,
    input  logic              cap_word,
    input  logic [IDX_W-1:0]  cap_idx,
    input  logic [ADDR_W-1:0] cap_base,
    input  logic [ADDR_W-1:0] cap_len,
    input  logic              cap_pred,
    input  logic [31:0]       cap_data,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);

    logic                      cap_accept;
    logic [ELEM_MAX_BYTES-1:0] byte_ok;
    logic [SLOT_W-1:0]         rd_slot;
    logic                      log_mask;
    logic [ADDR_W-1:0]         log_addr;
    logic [7:0]                log_data;
    logic                      clr_en;
    logic                      op_word;

    assign cap_accept = cap_valid && !busy;

    sal_byte_qual #(.ADDR_W(ADDR_W)) u_qual (
        .base    (cap_base),
        .len     (cap_len),
        .pred    (cap_pred),
        .byte_ok (byte_ok)
    );

    sal_log_store #(.LOG_BYTES(LOG_BYTES), .ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cap_accept),
        .wr_word (cap_word),
        .wr_idx  (cap_idx),
        .wr_base (cap_base),
        .wr_data (cap_data),
        .wr_ok   (byte_ok),
        .rd_slot (rd_slot),
        .rd_mask (log_mask),
        .rd_addr (log_addr),
        .rd_data (log_data),
        .clr_en  (clr_en),
        .op_word (op_word)
    );

    sal_commit_fsm #(.LOG_BYTES(LOG_BYTES), .ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op_word   (op_word),
        .rd_slot   (rd_slot),
        .log_mask  (log_mask),
        .log_addr  (log_addr),
        .log_data  (log_data),
        .clr_en    (clr_en),
        .busy      (busy),
        .done      (done),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

endmodule

// File: rtl/sal_checker.sv
module sal_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic mem_en,
    input logic mem_we
);

    AST_DONE_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);                 // R7
    AST_DONE_TO_IDLE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);                 // R7
    AST_START_BUSY:    assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);      // R7
    AST_BUSY_HOLD:     assert property (@(posedge clk) disable iff (!rst_n) (busy && !done) |=> busy);       // R7
    AST_DONE_IN_BUSY:  assert property (@(posedge clk) disable iff (!rst_n) done |-> busy);                  // R7
    AST_MEM_IN_BUSY:   assert property (@(posedge clk) disable iff (!rst_n) mem_en |-> busy);                // R9
    AST_WE_NEEDS_EN:   assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> mem_en);              // R9
    AST_IDLE_NO_START: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> !busy);    // R8

endmodule

bind scatter_acc_log sal_checker u_sal_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .mem_en (mem_en),
    .mem_we (mem_we)
);

// File: tb/sim_scatter_acc_log.sv
`timescale 1ns/1ps
module sim_scatter_acc_log;

    localparam int LB = 128;
    localparam int AW = 12;
    localparam int MEMSZ = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cap_valid = 1'b0;
    logic          cap_word = 1'b0;
    logic [5:0]    cap_idx = '0;
    logic [AW-1:0] cap_base = '0;
    logic [AW-1:0] cap_len = '0;
    logic          cap_pred = 1'b0;
    logic [31:0]   cap_data = '0;
    logic          start = 1'b0;
    logic          busy, done, mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata;

    always #10 clk = ~clk;

    scatter_acc_log #(.LOG_BYTES(LB), .ADDR_W(AW)) u0 (.*);

    logic [7:0] mem [MEMSZ];
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            mem_rdata <= mem[mem_addr];
        end
    end

    // Reference model
    logic [7:0]    m_data [LB];
    logic [AW-1:0] m_addr [LB];
    bit            m_mask [LB];
    bit            m_word;
    logic [7:0]    exp_mem [MEMSZ];

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit qual(input logic [AW-1:0] base, input logic [AW-1:0] len,
                                input int k, input bit pred);
        logic [AW-1:0] a, hi;
        a  = base + AW'(k);
        hi = base + len;
        return pred && (a <= hi);
    endfunction

    task automatic model_capture(input bit w, input int idx, input logic [AW-1:0] base,
                                 input logic [AW-1:0] len, input bit pred, input logic [31:0] d);
        int s, slot;
        s = w ? 4 : 2;
        slot = w ? (idx % 32) * 4 : (idx % 64) * 2;
        for (int k = 0; k < s; k++) begin
            m_data[slot+k] = d[8*k +: 8];
            m_addr[slot+k] = base + AW'(k);
            m_mask[slot+k] = qual(base, len, k, pred);
        end
        m_word = w;
    endtask

    task automatic model_commit();
        int s;
        logic [31:0] dst, inc, sum;
        s = m_word ? 4 : 2;
        for (int i = 0; i < LB; i += s) begin
            if (m_mask[i]) begin
                dst = 0; inc = 0;
                for (int j = 0; j < s; j++) begin
                    dst[8*j +: 8] = exp_mem[m_addr[i+j]];
                    inc[8*j +: 8] = m_data[i+j];
                end
                sum = dst + inc;
                for (int j = 0; j < s; j++) begin
                    exp_mem[m_addr[i+j]] = sum[8*j +: 8];
                    m_mask[i+j] = 1'b0;
                    m_data[i+j] = 8'h00;
                end
            end
        end
    endtask

    task automatic capture(input bit w, input int idx, input logic [AW-1:0] base,
                           input logic [AW-1:0] len, input bit pred, input logic [31:0] d);
        @(negedge clk);
        cap_valid = 1'b1; cap_word = w; cap_idx = 6'(idx);
        cap_base = base; cap_len = len; cap_pred = pred; cap_data = d;
        model_capture(w, idx, base, len, pred, d);
        @(negedge clk);
        cap_valid = 1'b0;
    endtask

    task automatic compare_mem(input string req, input string what);
        int bad = 0;
        int first = -1;
        for (int a = 0; a < MEMSZ; a++) begin
            if (mem[a] !== exp_mem[a]) begin
                bad++;
                if (first < 0) first = a;
            end
        end
        if (first < 0) check(1'b1, req, what, 0, 0);
        else check(1'b0, req, {what, " byte at addr ", $sformatf("%0h", first)},
                   mem[first], exp_mem[first]);
    endtask

    task automatic commit(input bit inject, input string req, input string what);
        int dones = 0;
        int cyc = 0;
        bit seen = 1'b0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy == 1'b1, "R7", "busy after start", busy, 1);
        while (!seen && cyc < 4000) begin
            if (done) begin dones++; seen = 1'b1; end
            if (!seen) begin
                if (inject && cyc == 3) begin
                    // R8: capture and start while busy must be ignored
                    cap_valid = 1'b1; cap_word = 1'b0; cap_idx = 6'd0;
                    cap_base = 12'h400; cap_len = 12'd3; cap_pred = 1'b1; cap_data = 32'h0000_3355;
                    start = 1'b1;
                end else begin
                    cap_valid = 1'b0; start = 1'b0;
                end
                @(negedge clk);
                cyc++;
            end
        end
        cap_valid = 1'b0; start = 1'b0;
        check(seen, "R7", "done reached", seen, 1);
        @(negedge clk);
        check(done == 1'b0, "R7", "done is single pulse", done, 0);
        check(busy == 1'b0, "R7", "busy low after done", busy, 0);
        model_commit();
        compare_mem(req, what);
    endtask

    task automatic preload(input int a, input logic [7:0] v);
        mem[a] = v; exp_mem[a] = v;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        for (int a = 0; a < MEMSZ; a++) begin
            mem[a] = 8'($urandom); exp_mem[a] = mem[a];
        end
        for (int s = 0; s < LB; s++) begin
            m_data[s] = 0; m_addr[s] = 0; m_mask[s] = 0;
        end
        m_word = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        check(busy == 1'b0, "R10", "busy after reset", busy, 0);
        check(done == 1'b0, "R10", "done after reset", done, 0);
        check(mem_en == 1'b0, "R10", "mem_en after reset", mem_en, 0);
        commit(1'b0, "R10", "empty log commit");

        // R5: halfword truncation, no carry out of element
        preload(12'h100, 8'hFF); preload(12'h101, 8'hFF); preload(12'h102, 8'h55);
        capture(1'b0, 3, 12'h100, 12'd1, 1'b1, 32'h0000_0001);
        commit(1'b0, "R5", "halfword wrap truncation");

        // R4: zero length marks only first byte, whole word still applied
        capture(1'b1, 2, 12'h200, 12'd0, 1'b1, 32'h0101_0101);
        commit(1'b0, "R4", "first byte decides word");

        // R2: predicate false and wrapping bound skip the element
        capture(1'b1, 0, 12'h210, 12'd3, 1'b0, 32'h1111_1111);
        capture(1'b1, 1, 12'hFFE, 12'd3, 1'b1, 32'h2222_2222);
        commit(1'b0, "R2", "predicate and wrapped bound");

        // R5: two elements accumulate into the same bytes
        capture(1'b0, 0, 12'h300, 12'd5, 1'b1, 32'h0000_80F0);
        capture(1'b0, 5, 12'h300, 12'd5, 1'b1, 32'h0000_0120);
        commit(1'b0, "R5", "overlapping targets");

        // R1: word index wraps and last write to a slot wins
        capture(1'b1, 40, 12'h320, 12'd3, 1'b1, 32'hDEAD_0001);
        capture(1'b1, 8, 12'h340, 12'd3, 1'b1, 32'h0102_0304);
        commit(1'b0, "R1", "word index wrap and overwrite");

        // R3: size of last capture governs the stride
        capture(1'b0, 4, 12'h360, 12'd1, 1'b1, 32'h0000_0A0B);
        capture(1'b0, 5, 12'h380, 12'd1, 1'b1, 32'h0000_0C0D);
        capture(1'b1, 4, 12'h3A0, 12'd3, 1'b0, 32'h0505_0505);
        capture(1'b1, 7, 12'h3C0, 12'd3, 1'b1, 32'h0000_0007);
        commit(1'b0, "R3", "size from last capture");

        // R8 then R6: injected capture/start during commit, then idle commit
        for (int e = 0; e < 10; e++)
            capture(1'b0, e, 12'(12'h500 + 2*e), 12'd1, 1'b1, 32'(e + 1));
        commit(1'b1, "R8", "commit with injected requests");
        commit(1'b0, "R6", "second commit changes nothing");

        // R1 R2 R4 R5 R9: constrained random rounds
        for (int r = 0; r < 8; r++) begin
            bit w;
            int n;
            w = 1'($urandom % 2);
            n = 1 + int'($urandom % 20);
            for (int e = 0; e < n; e++) begin
                capture(w, int'($urandom % (w ? 32 : 64)), 12'(12'h600 + $urandom % 64),
                        12'($urandom % 6), ($urandom % 4) != 0, $urandom);
            end
            commit(1'b0, "R5", $sformatf("random round %0d", r));
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule